// File: doc/BRIEF.md
# Interrupt Priority Level Gate

This block sits in front of a 15-source interrupt controller. It holds the processor's current priority level and decides, for each request the controller raises, whether it may interrupt now. A request on line `n` has priority level `27 - n`, so line 0 ranks highest. A request that outranks the current level is granted, and the level rises to match it. A request that does not outrank the level is parked in a pending register. At that moment the block also writes a fresh mask word to the controller, so that sources which cannot win stop disturbing it.

Software moves the level through a small valid/ready handshake. A raise command carries a new, higher level. A lower command carries the level to return to once service ends. On a lower, the block rewrites the mask for the new level and looks through the pending register. If any parked request now outranks the new level, it replays the one with the highest level (the lowest line number) and clears its pending bit. Raising the level never touches the mask: the mask is brought up to date only when a request is actually refused.

Top module: `irq_level_gate`

## Requirements
- R1: After a synchronous reset the current level is 0, the pending register and mask word are all zero, and no grant or mask write is signalled.
- R2: A request on line n (n < 15) has level 27 - n. It is granted when that level is strictly greater than the current level. One cycle later `grant_o` pulses with `grant_line_o` = n and `grant_replay_o` = 0, and the current level equals 27 - n.
- R3: A request on line n whose level is less than or equal to the current level sets bit n of `pend_o`, produces no grant, and leaves the current level unchanged.
- R4: A refused request writes the mask word: one cycle later `mask_wr_o` pulses, and `mask_o` bit n is 1 exactly when 27 - n is less than or equal to the current level. Between writes, `mask_o` holds its value.
- R5: A raise command (`lvl_raise_i` = 1) whose value is greater than the current level sets the level to that value. A raise whose value is not greater is ignored. A raise never pulses `mask_wr_o` or changes `mask_o`.
- R6: A lower command (`lvl_raise_i` = 0) whose value is less than or equal to the current level sets the level to that value. It also writes the mask word computed for that value, with a `mask_wr_o` pulse.
- R7: On such a lower, if any pending line m has 27 - m greater than the new value, the lowest such m is granted in the same update. `grant_o` and `grant_replay_o` pulse with `grant_line_o` = m, bit m of `pend_o` clears, and the level becomes 27 - m. Each lower replays at most one request.
- R8: A lower command whose value is greater than the current level is ignored: level, pending register and mask are unchanged, and there is no mask write and no grant.
- R9: A request with line number 15 has no effect on level, pending register, mask or grant.
- R10: A request takes precedence over a level command. `lvl_ready_o` is 0 while `req_valid_i` is 1, and a level command offered in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Interrupt request from the controller |
| req_line_i | input | 4 | Line number of the request |
| lvl_valid_i | input | 1 | Level command valid |
| lvl_ready_o | output | 1 | Level command accepted this cycle |
| lvl_raise_i | input | 1 | 1 = raise command, 0 = lower command |
| lvl_value_i | input | 5 | New level value carried by the command |
| grant_o | output | 1 | One-cycle pulse: a request is granted |
| grant_line_o | output | 4 | Line number of the granted request |
| grant_replay_o | output | 1 | The grant came from the pending register |
| mask_o | output | 15 | Mask word for the downstream controller |
| mask_wr_o | output | 1 | One-cycle pulse: `mask_o` was rewritten |
| level_o | output | 5 | Current priority level |
| pend_o | output | 15 | Pending register |

## Verification
The assertions assume that the controller offers at most one request per cycle and that a level command is held until `lvl_ready_o` is seen. The bench keeps to both assumptions. It drives one operation at a time on the falling edge and releases it after a single cycle, and it only offers a level command together with a request in the one test that checks precedence. Line 15 and level values up to 31 are legal stimulus, and the sweeps cover them.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;
  // Priority level assigned to an interrupt line; lower line numbers rank higher.
  function automatic int line_to_level(input int base, input int line);
    return base - line;
  endfunction
endpackage

// File: rtl/irq_level_mask.sv
module irq_level_mask #(
  parameter int NUM_LINES  = 15,
  parameter int LVL_W      = 5,
  parameter int LEVEL_BASE = 27
) (
  input  logic [LVL_W-1:0]     level_i,
  output logic [NUM_LINES-1:0] mask_o
);
  import irq_level_pkg::*;

  // A source is blocked once its own level cannot beat the given level.
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_bit
    assign mask_o[g] = (line_to_level(LEVEL_BASE, g) <= int'(level_i));
  end
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
  parameter int NUM_LINES = 15,
  parameter int IDX_W     = 4
) (
  input  logic [NUM_LINES-1:0] cand_i,
  output logic                 found_o,
  output logic [IDX_W-1:0]     idx_o
);
  // Lowest set index wins: it carries the highest level.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate #(
  parameter int NUM_LINES  = 15,
  parameter int LVL_W      = 5,
  parameter int LEVEL_BASE = 27,
  parameter int IDX_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid_i,
  input  logic [IDX_W-1:0]     req_line_i,
  input  logic                 lvl_valid_i,
  output logic                 lvl_ready_o,
  input  logic                 lvl_raise_i,
  input  logic [LVL_W-1:0]     lvl_value_i,
  output logic                 grant_o,
  output logic [IDX_W-1:0]     grant_line_o,
  output logic                 grant_replay_o,
  output logic [NUM_LINES-1:0] mask_o,
  output logic                 mask_wr_o,
  output logic [LVL_W-1:0]     level_o,
  output logic [NUM_LINES-1:0] pend_o
);
  import irq_level_pkg::*;

  logic [LVL_W-1:0]     level_q;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] mask_cur;
  logic [NUM_LINES-1:0] mask_new;
  logic [NUM_LINES-1:0] replay_cand;
  logic                 replay_found;
  logic [IDX_W-1:0]     replay_idx;
  logic                 req_ok;
  logic [LVL_W-1:0]     req_lvl;
  logic [LVL_W-1:0]     replay_lvl;
  logic                 lvl_fire;

  // Requests outrank level commands in the same cycle.
  assign lvl_ready_o = ~req_valid_i;
  assign lvl_fire    = lvl_valid_i & lvl_ready_o;
  assign req_ok      = req_valid_i && (int'(req_line_i) < NUM_LINES);
  assign req_lvl     = LVL_W'(line_to_level(LEVEL_BASE, int'(req_line_i)));
  assign replay_lvl  = LVL_W'(line_to_level(LEVEL_BASE, int'(replay_idx)));

  irq_level_mask #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W), .LEVEL_BASE(LEVEL_BASE))
    u_mask_cur (.level_i(level_q), .mask_o(mask_cur));

  irq_level_mask #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W), .LEVEL_BASE(LEVEL_BASE))
    u_mask_new (.level_i(lvl_value_i), .mask_o(mask_new));

  assign replay_cand = pend_q & ~mask_new;

  irq_level_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W))
    u_pick (.cand_i(replay_cand), .found_o(replay_found), .idx_o(replay_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q        <= '0;
      pend_q         <= '0;
      mask_o         <= '0;
      mask_wr_o      <= 1'b0;
      grant_o        <= 1'b0;
      grant_line_o   <= '0;
      grant_replay_o <= 1'b0;
    end else begin
      grant_o        <= 1'b0;
      grant_replay_o <= 1'b0;
      mask_wr_o      <= 1'b0;
      if (req_ok) begin
        if (req_lvl > level_q) begin
          level_q      <= req_lvl;
          grant_o      <= 1'b1;
          grant_line_o <= req_line_i;
        end else begin
          pend_q[req_line_i] <= 1'b1;
          mask_o             <= mask_cur;
          mask_wr_o          <= 1'b1;
        end
      end else if (lvl_fire) begin
        if (lvl_raise_i) begin
          if (lvl_value_i > level_q) level_q <= lvl_value_i;
        end else if (lvl_value_i <= level_q) begin
          mask_o    <= mask_new;
          mask_wr_o <= 1'b1;
          if (replay_found) begin
            level_q            <= replay_lvl;
            pend_q[replay_idx] <= 1'b0;
            grant_o            <= 1'b1;
            grant_replay_o     <= 1'b1;
            grant_line_o       <= replay_idx;
          end else begin
            level_q <= lvl_value_i;
          end
        end
      end
    end
  end

  assign level_o = level_q;
  assign pend_o  = pend_q;

  // A refused request is parked and triggers a mask write, never a grant.
  p_reject_parks_r3: assert property (@(posedge clk) disable iff (rst)
    (req_ok && req_lvl <= level_q) |=> (pend_q[$past(req_line_i)] && mask_wr_o && !grant_o));

  // An outranking request is granted with its own line number.
  p_accept_strict_r2: assert property (@(posedge clk) disable iff (rst)
    (req_ok && req_lvl > level_q) |=> (grant_o && !grant_replay_o && grant_line_o == $past(req_line_i)));

  // Every grant leaves the level equal to the granted line's level.
  p_grant_level_r7: assert property (@(posedge clk) disable iff (rst)
    grant_o |-> (int'(level_q) == LEVEL_BASE - int'(grant_line_o)));

  // Raising the level never writes the mask.
  p_raise_no_mask_r5: assert property (@(posedge clk) disable iff (rst)
    (lvl_fire && lvl_raise_i) |=> (!mask_wr_o && mask_o == $past(mask_o)));

  // A lower command above the current level changes nothing.
  p_lower_above_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (lvl_fire && !lvl_raise_i && lvl_value_i > level_q)
      |=> (level_q == $past(level_q) && pend_q == $past(pend_q) && !mask_wr_o && !grant_o));

  // A replayed line no longer sits in the pending register.
  p_replay_clears_r7: assert property (@(posedge clk) disable iff (rst)
    grant_replay_o |-> (grant_o && !pend_q[grant_line_o]));

  // Line numbers outside the source range have no effect.
  p_bad_line_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && int'(req_line_i) >= NUM_LINES)
      |=> (!grant_o && !mask_wr_o && pend_q == $past(pend_q) && level_q == $past(level_q)));
endmodule

// File: tb/tb_irq_level_gate.sv
module tb_irq_level_gate;
  localparam int N    = 15;
  localparam int BASE = 27;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid_i = 1'b0;
  logic [3:0]  req_line_i = '0;
  logic        lvl_valid_i = 1'b0;
  logic        lvl_ready_o;
  logic        lvl_raise_i = 1'b0;
  logic [4:0]  lvl_value_i = '0;
  logic        grant_o;
  logic [3:0]  grant_line_o;
  logic        grant_replay_o;
  logic [N-1:0] mask_o;
  logic        mask_wr_o;
  logic [4:0]  level_o;
  logic [N-1:0] pend_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Expected state, computed from the requirements.
  int          m_level;
  logic [N-1:0] m_pend;
  logic [N-1:0] m_mask;
  logic        e_grant, e_replay, e_wr;
  int          e_line;

  always #2 clk = ~clk;

  irq_level_gate dut (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid_i), .req_line_i(req_line_i),
    .lvl_valid_i(lvl_valid_i), .lvl_ready_o(lvl_ready_o),
    .lvl_raise_i(lvl_raise_i), .lvl_value_i(lvl_value_i),
    .grant_o(grant_o), .grant_line_o(grant_line_o), .grant_replay_o(grant_replay_o),
    .mask_o(mask_o), .mask_wr_o(mask_wr_o), .level_o(level_o), .pend_o(pend_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [N-1:0] mask_of(input int l);
    logic [N-1:0] m;
    for (int n = 0; n < N; n++) m[n] = ((BASE - n) <= l);
    return m;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "grant", int'(grant_o), int'(e_grant));
    if (e_grant) begin
      chk(tag, "grant_line", int'(grant_line_o), e_line);
      chk(tag, "replay", int'(grant_replay_o), int'(e_replay));
    end
    chk(tag, "mask_wr", int'(mask_wr_o), int'(e_wr));
    chk(tag, "mask", int'(mask_o), int'(m_mask));
    chk(tag, "level", int'(level_o), m_level);
    chk(tag, "pend", int'(pend_o), int'(m_pend));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid_i = 1'b0; lvl_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_level = 0; m_pend = '0; m_mask = '0;
    e_grant = 0; e_replay = 0; e_wr = 0; e_line = 0;
  endtask

  task automatic do_req(input int line, input string tag);
    @(negedge clk);
    req_valid_i = 1'b1; req_line_i = 4'(line);
    e_grant = 0; e_replay = 0; e_wr = 0;
    if (line < N) begin
      if (BASE - line > m_level) begin
        m_level = BASE - line; e_grant = 1; e_line = line;
      end else begin
        m_pend[line] = 1'b1; m_mask = mask_of(m_level); e_wr = 1;
      end
    end
    @(negedge clk);
    req_valid_i = 1'b0;
    chk_all(tag);
  endtask

  task automatic do_lvl(input bit raise, input int val, input string tag);
    @(negedge clk);
    lvl_valid_i = 1'b1; lvl_raise_i = raise; lvl_value_i = 5'(val);
    e_grant = 0; e_replay = 0; e_wr = 0;
    if (raise) begin
      if (val > m_level) m_level = val;
    end else if (val <= m_level) begin
      m_level = val; m_mask = mask_of(val); e_wr = 1;
      for (int n = 0; n < N; n++) begin
        if (!e_grant && m_pend[n] && (BASE - n) > val) begin
          e_grant = 1; e_replay = 1; e_line = n;
          m_pend[n] = 1'b0; m_level = BASE - n;
        end
      end
    end
    @(negedge clk);
    lvl_valid_i = 1'b0;
    chk_all(tag);
  endtask

  initial begin
    do_reset();
    // R1: reset state
    e_grant = 0; e_wr = 0;
    chk_all("R1");

    // R2 R3 R4 R9: every starting level against every line number
    for (int l = 0; l < 32; l++) begin
      for (int line = 0; line < 16; line++) begin
        do_reset();
        do_lvl(1'b1, l, "R5");
        do_req(line, (line >= N) ? "R9" : ((BASE - line > l) ? "R2" : "R3_R4"));
      end
    end

    // R7 R6: fill pending at level 31, then lower to each value and drain replays
    for (int v = 0; v < 32; v++) begin
      do_reset();
      do_lvl(1'b1, 31, "R5");
      for (int line = 0; line < 16; line++) do_req(line, "R3_R4");
      for (int k = 0; k < 16; k++) do_lvl(1'b0, v, "R6_R7");
    end

    // R5: raises below or equal are ignored and never write the mask
    do_reset();
    do_lvl(1'b1, 20, "R5");
    do_req(10, "R3_R4");
    do_lvl(1'b1, 25, "R5");
    do_lvl(1'b1, 22, "R5");
    do_lvl(1'b1, 25, "R5");

    // R8: lower above current is ignored
    do_lvl(1'b0, 30, "R8");
    do_lvl(1'b0, 26, "R8");
    do_lvl(1'b0, 16, "R6_R7");

    // R10: request and level command in the same cycle
    do_reset();
    do_lvl(1'b1, 14, "R5");
    @(negedge clk);
    req_valid_i = 1'b1; req_line_i = 4'd14;
    lvl_valid_i = 1'b1; lvl_raise_i = 1'b1; lvl_value_i = 5'd30;
    #1;
    chk("R10", "lvl_ready", int'(lvl_ready_o), 0);
    m_pend[14] = 1'b1; m_mask = mask_of(14);
    e_grant = 0; e_wr = 1;
    @(negedge clk);
    req_valid_i = 1'b0; lvl_valid_i = 1'b0;
    chk_all("R10");
    #1;
    chk("R10", "lvl_ready_idle", int'(lvl_ready_o), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule